// File: doc/BRIEF.md
# Modem Status Word and Interrupt Request Logic

This block keeps the primary 8-bit status word that a host reads from a packet data modem, and decides when that word should raise an interrupt. The modem datapath feeds it condition inputs: a buffer-ready strobe, the fill level of the interleave buffer, an overflow level, an error-correction flag, a data-quality-ready level and a packet-detect level. Task writes, mode register writes and a secondary status byte are also inputs. From these the block registers each status bit once per clock, looks for 0-to-1 transitions on the bits that can interrupt, and keeps a sticky request flag that drives an active-low interrupt pin.

Some updates must not interrupt. These are forced updates, caused by a reset task or by a change of the baseband-enable or transmit mode bit. The request remembers whether the primary word or the secondary byte raised it. Reading the primary word clears only a request that the primary word raised. A request raised by the secondary byte stays until the host reads the secondary byte.

Top module: `modem_irq_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status1_o reads 8'h60: bit 6 (buffer free) and bit 5 (interleave empty) are 1, every other bit is 0, and irq_n_o is 1. The mode register resets to receive mode with every enable at 0.
- R2: When buf_ready_i is high and no forced update or data task happens in that cycle, bit 6 becomes 1 after the edge. If bit 6 was 0 before, the request bit 7 is set at the same edge.
- R3: Two events are forced updates: a task write with code 4'h1 (reset task), and a mode write that changes mode_bb_en_i or mode_tx_i from the held value. A forced update sets bits 6 and 5 to 1 and never raises the request.
- R4: A task write with a code other than 4'h0 (no-op), 4'h1 (reset) or 4'h2 (stop output) clears bit 6, and this clear takes priority over buf_ready_i. Codes 4'h0 and 4'h2 leave bit 6 unchanged.
- R5: In transmit mode (held mode_tx = 1, shown on bit 1), bit 5 follows ilv_level_i < 2 at each edge. A 0-to-1 change of bit 5 that is not forced raises the request. In receive mode bit 5 holds its value except under a forced update.
- R6: A 0-to-1 change of bit 2 (data-quality-ready, which mirrors dq_ready_i) raises the request only while the held data-quality enable is 1.
- R7: A 0-to-1 change of bit 4 (overflow, which mirrors ovf_i) always raises the request.
- R8: A 0-to-1 change of bit 0 (packet detect, which mirrors pkt_det_i) raises the request only if pkt_det_en_i is 1 in that cycle.
- R9: A 0-to-1 change of stat2_i bit 7, 3, 2, 1 or 0 raises the request. The edge is taken against the value of stat2_i in the previous cycle. Changes on bits 6 to 4 never raise it.
- R10: A request raised only by the primary word clears at the edge where rd_stat1_i is high.
- R11: A request raised by the secondary byte is not cleared by rd_stat1_i. It clears at the edge where rd_stat2_i is high. If both the primary word and the secondary byte raised the request, both reads are needed before it clears.
- R12: irq_n_o is 0 exactly when bit 7 is 1 and the held interrupt enable is 1.
- R13: A new qualifying transition in the same cycle as a clearing read leaves the request set.
- R14: Bits 4, 3, 2 and 0 show ovf_i, fec_i, dq_ready_i and pkt_det_i one edge later. Bit 1 shows the held transmit mode bit, which changes only on a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_ready_i | input | 1 | Datapath strobe: data buffer is available |
| ilv_level_i | input | LVL_W | Bits remaining in the interleave buffer |
| ovf_i | input | 1 | Interleave overflow condition |
| fec_i | input | 1 | Error-correction status condition |
| dq_ready_i | input | 1 | Data-quality reading ready |
| pkt_det_i | input | 1 | Packet detected |
| pkt_det_en_i | input | 1 | Packet-detect interrupt enable from the command register |
| task_wr_i | input | 1 | Task written to the command register this cycle |
| task_code_i | input | 4 | Code of the written task |
| mode_wr_i | input | 1 | Mode register written this cycle |
| mode_bb_en_i | input | 1 | New baseband-enable value |
| mode_tx_i | input | 1 | New transmit (1) / receive (0) value |
| mode_irq_en_i | input | 1 | New interrupt pin enable value |
| mode_dq_en_i | input | 1 | New data-quality interrupt enable value |
| stat2_i | input | 8 | Secondary status byte |
| rd_stat1_i | input | 1 | Host reads the primary status word |
| rd_stat2_i | input | 1 | Host reads the secondary status byte |
| status1_o | output | 8 | Primary status word |
| irq_n_o | output | 1 | Interrupt request pin, active low |

## Verification
Several rules are checked by the assertions on every cycle. The pin never goes low without bit 7 set. A reset task always leaves both buffer flags at 1. A data task always clears buffer free. In transmit mode a low interleave level always sets the empty flag. A rising overflow always sets the request, even when a primary read happens in the same cycle. The mode flag moves only on a mode write. Other behaviour needs the bench's scenarios. These are the absence of a request after forced updates, and the gating by the data-quality and packet-detect enables. They also include the split between primary and secondary clearing, the masking of secondary bits 6 to 4, and the pin staying high while the interrupt enable is off.

// File: rtl/modem_stat_pkg.sv
// Package: shared constants and types for the modem status/interrupt block.
// Assumes task codes are 4 bits wide and that status bit positions are fixed
// by the host software that decodes the primary status word.
package modem_stat_pkg;

    localparam int TASK_W = 4;

    // Task codes that do not consume the data buffer
    localparam logic [TASK_W-1:0] TASK_NOP   = 4'h0;
    localparam logic [TASK_W-1:0] TASK_RESET = 4'h1;
    localparam logic [TASK_W-1:0] TASK_STOP  = 4'h2;

    // Bit positions in the primary status word
    localparam int BIT_IRQ  = 7;
    localparam int BIT_BF   = 6;
    localparam int BIT_IBE  = 5;
    localparam int BIT_OVF  = 4;
    localparam int BIT_FEC  = 3;
    localparam int BIT_DQ   = 2;
    localparam int BIT_MODE = 1;
    localparam int BIT_PKT  = 0;

    // Number of status bits that plainly mirror a datapath level
    localparam int N_MIRROR = 4;

    // Held mode register contents
    typedef struct packed {
        logic bb_en;
        logic tx;
        logic irq_en;
        logic dq_en;
    } mode_t;

    // Registered status flags (excluding request and mode flag)
    typedef struct packed {
        logic bf;
        logic ibe;
        logic ovf;
        logic fec;
        logic dq;
        logic pkt;
    } flags_t;

    // True for tasks that occupy the data buffer
    function automatic logic is_data_task(input logic [TASK_W-1:0] code);
        return (code != TASK_NOP) && (code != TASK_RESET) && (code != TASK_STOP);
    endfunction

endpackage

// File: rtl/modem_stat_mode.sv
// Module: mode register holder.
// Captures the mode fields on a mode write and flags a forced update when
// the baseband-enable or transmit bit changes. Assumes one write per cycle.
module modem_stat_mode
    import modem_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_wr_i,
    input  mode_t mode_new_i,
    output mode_t mode_q_o,
    output logic  mode_force_o
);

    mode_t mode_q;

    // Purpose: hold the mode fields, reset to receive with enables off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr_i) begin
            mode_q <= mode_new_i;
        end
    end

    // Purpose: detect a write that alters baseband-enable or direction
    always_comb begin
        mode_force_o = mode_wr_i &&
                       ((mode_new_i.bb_en != mode_q.bb_en) ||
                        (mode_new_i.tx    != mode_q.tx));
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/modem_stat_word.sv
// Module: status flag register.
// Computes next values of the buffer-free, interleave-empty and mirrored
// flags and registers them. Exposes both current and next values so the
// interrupt logic can detect 0-to-1 changes. Assumes the interleave level
// input is only meaningful in transmit mode.
module modem_stat_word
    import modem_stat_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int IBE_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_i,
    input  logic             data_task_i,
    input  logic             buf_ready_i,
    input  logic             tx_mode_i,
    input  logic [LVL_W-1:0] ilv_level_i,
    input  logic             ovf_i,
    input  logic             fec_i,
    input  logic             dq_ready_i,
    input  logic             pkt_det_i,
    output flags_t           cur_o,
    output flags_t           nxt_o
);

    localparam logic [LVL_W-1:0] THRESH = LVL_W'(IBE_THRESH);

    logic bf_q, ibe_q, bf_d, ibe_d;
    logic [N_MIRROR-1:0] mir_in, mir_q;

    // Purpose: buffer-free next value, forced > data-task clear > ready set
    always_comb begin
        if (force_i)            bf_d = 1'b1;
        else if (data_task_i)   bf_d = 1'b0;
        else if (buf_ready_i)   bf_d = 1'b1;
        else                    bf_d = bf_q;
    end

    // Purpose: interleave-empty next value, level-driven only when transmitting
    always_comb begin
        if (force_i)            ibe_d = 1'b1;
        else if (tx_mode_i)     ibe_d = (ilv_level_i < THRESH);
        else                    ibe_d = ibe_q;
    end

    // Purpose: register the two buffer flags, both set out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bf_q  <= 1'b1;
            ibe_q <= 1'b1;
        end else begin
            bf_q  <= bf_d;
            ibe_q <= ibe_d;
        end
    end

    assign mir_in = {ovf_i, fec_i, dq_ready_i, pkt_det_i};

    // One register per mirrored condition
    for (genvar g = 0; g < N_MIRROR; g++) begin : g_mirror
        // Purpose: sample one datapath level into its status bit
        always_ff @(posedge clk) begin
            if (!rst_n) mir_q[g] <= 1'b0;
            else        mir_q[g] <= mir_in[g];
        end
    end

    // Purpose: assemble current and next flag views
    always_comb begin
        cur_o = '{bf: bf_q, ibe: ibe_q, ovf: mir_q[3], fec: mir_q[2],
                  dq: mir_q[1], pkt: mir_q[0]};
        nxt_o = '{bf: bf_d, ibe: ibe_d, ovf: mir_in[3], fec: mir_in[2],
                  dq: mir_in[1], pkt: mir_in[0]};
    end

endmodule

// File: rtl/modem_stat_irq.sv
// Module: interrupt request logic.
// Detects qualifying 0-to-1 changes on primary flags and on masked bits of
// the secondary byte, and keeps separate sticky origins so each is cleared
// only by a read of its own register. A new rise wins over a same-cycle read.
module modem_stat_irq
    import modem_stat_pkg::*;
#(
    parameter int          S2_W    = 8,
    parameter logic [7:0]  S2_MASK = 8'h8F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  flags_t          cur_i,
    input  flags_t          nxt_i,
    input  logic            force_i,
    input  logic            dq_en_i,
    input  logic            pkt_en_i,
    input  logic [S2_W-1:0] stat2_i,
    input  logic            rd_stat1_i,
    input  logic            rd_stat2_i,
    output logic            irq_o
);

    logic [S2_W-1:0] s2_q;
    logic            from_p1_q, from_p2_q;
    logic            rise_p1, rise_p2;

    // Purpose: collect qualifying primary-word rises
    always_comb begin
        rise_p1 = (nxt_i.bf  & ~cur_i.bf  & ~force_i) |
                  (nxt_i.ibe & ~cur_i.ibe & ~force_i) |
                  (nxt_i.ovf & ~cur_i.ovf)            |
                  (nxt_i.dq  & ~cur_i.dq  & dq_en_i)  |
                  (nxt_i.pkt & ~cur_i.pkt & pkt_en_i);
        rise_p2 = |(stat2_i & ~s2_q & S2_MASK[S2_W-1:0]);
    end

    // Purpose: remember the secondary byte for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= stat2_i;
    end

    // Purpose: sticky request origins, set wins over clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_p1_q <= 1'b0;
            from_p2_q <= 1'b0;
        end else begin
            if (rise_p1)         from_p1_q <= 1'b1;
            else if (rd_stat1_i) from_p1_q <= 1'b0;
            if (rise_p2)         from_p2_q <= 1'b1;
            else if (rd_stat2_i) from_p2_q <= 1'b0;
        end
    end

    assign irq_o = from_p1_q | from_p2_q;

endmodule

// File: rtl/modem_irq_status.sv
// Module: top of the modem status word and interrupt request block.
// Combines the mode register, the status flag register and the request
// logic, and forms the host-visible word and active-low pin. Assumes all
// inputs are synchronous to clk and that read strobes last one cycle.
module modem_irq_status
    import modem_stat_pkg::*;
#(
    parameter int         LVL_W      = 8,
    parameter int         IBE_THRESH = 2,
    parameter logic [7:0] S2_MASK    = 8'h8F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_ready_i,
    input  logic [LVL_W-1:0] ilv_level_i,
    input  logic             ovf_i,
    input  logic             fec_i,
    input  logic             dq_ready_i,
    input  logic             pkt_det_i,
    input  logic             pkt_det_en_i,
    input  logic             task_wr_i,
    input  logic [3:0]       task_code_i,
    input  logic             mode_wr_i,
    input  logic             mode_bb_en_i,
    input  logic             mode_tx_i,
    input  logic             mode_irq_en_i,
    input  logic             mode_dq_en_i,
    input  logic [7:0]       stat2_i,
    input  logic             rd_stat1_i,
    input  logic             rd_stat2_i,
    output logic [7:0]       status1_o,
    output logic             irq_n_o
);

    mode_t  mode_new, mode_q;
    logic   mode_force, reset_task, data_task, force_upd, irq;
    flags_t cur, nxt;

    assign mode_new = '{bb_en: mode_bb_en_i, tx: mode_tx_i,
                        irq_en: mode_irq_en_i, dq_en: mode_dq_en_i};

    // Purpose: classify the task written this cycle
    always_comb begin
        reset_task = task_wr_i && (task_code_i == TASK_RESET);
        data_task  = task_wr_i && is_data_task(task_code_i);
        force_upd  = reset_task || mode_force;
    end

    modem_stat_mode u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (mode_wr_i),
        .mode_new_i   (mode_new),
        .mode_q_o     (mode_q),
        .mode_force_o (mode_force)
    );

    modem_stat_word #(
        .LVL_W      (LVL_W),
        .IBE_THRESH (IBE_THRESH)
    ) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_i     (force_upd),
        .data_task_i (data_task),
        .buf_ready_i (buf_ready_i),
        .tx_mode_i   (mode_q.tx),
        .ilv_level_i (ilv_level_i),
        .ovf_i       (ovf_i),
        .fec_i       (fec_i),
        .dq_ready_i  (dq_ready_i),
        .pkt_det_i   (pkt_det_i),
        .cur_o       (cur),
        .nxt_o       (nxt)
    );

    modem_stat_irq #(
        .S2_W    (8),
        .S2_MASK (S2_MASK)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (cur),
        .nxt_i      (nxt),
        .force_i    (force_upd),
        .dq_en_i    (mode_q.dq_en),
        .pkt_en_i   (pkt_det_en_i),
        .stat2_i    (stat2_i),
        .rd_stat1_i (rd_stat1_i),
        .rd_stat2_i (rd_stat2_i),
        .irq_o      (irq)
    );

    // Purpose: place each flag at its host-visible bit position
    always_comb begin
        status1_o           = '0;
        status1_o[BIT_IRQ]  = irq;
        status1_o[BIT_BF]   = cur.bf;
        status1_o[BIT_IBE]  = cur.ibe;
        status1_o[BIT_OVF]  = cur.ovf;
        status1_o[BIT_FEC]  = cur.fec;
        status1_o[BIT_DQ]   = cur.dq;
        status1_o[BIT_MODE] = mode_q.tx;
        status1_o[BIT_PKT]  = cur.pkt;
    end

    assign irq_n_o = ~(irq & mode_q.irq_en);

endmodule

// File: rtl/modem_stat_chk.sv
// Module: assertion checker for modem_irq_status, bound to every instance.
// Observes ports only.
module modem_stat_chk #(
    parameter int LVL_W      = 8,
    parameter int IBE_THRESH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] ilv_level_i,
    input logic             ovf_i,
    input logic             task_wr_i,
    input logic [3:0]       task_code_i,
    input logic             mode_wr_i,
    input logic             rd_stat1_i,
    input logic [7:0]       status1_o,
    input logic             irq_n_o
);

    assert_pin_needs_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> status1_o[7]);

    assert_reset_task_sets_buffers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (task_wr_i && task_code_i == 4'h1) |=> (status1_o[6] && status1_o[5]));

    assert_data_task_clears_bf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (task_wr_i && task_code_i > 4'h2 && !mode_wr_i) |=> !status1_o[6]);

    assert_low_level_sets_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status1_o[1] && !mode_wr_i && ilv_level_i < LVL_W'(IBE_THRESH)) |=> status1_o[5]);

    assert_ovf_rise_beats_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !status1_o[4] && rd_stat1_i) |=> status1_o[7]);

    assert_mode_flag_steady_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_i |=> $stable(status1_o[1]));

endmodule

bind modem_irq_status modem_stat_chk #(
    .LVL_W      (LVL_W),
    .IBE_THRESH (IBE_THRESH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ilv_level_i (ilv_level_i),
    .ovf_i       (ovf_i),
    .task_wr_i   (task_wr_i),
    .task_code_i (task_code_i),
    .mode_wr_i   (mode_wr_i),
    .rd_stat1_i  (rd_stat1_i),
    .status1_o   (status1_o),
    .irq_n_o     (irq_n_o)
);

// File: tb/tb_modem_irq_status.sv
// Bench: vector table in receive mode, then directed transmit-mode,
// enable and reset scenarios. Inputs change on negedge, outputs are
// sampled 1 ns after posedge.
module tb_modem_irq_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       buf_ready_i, ovf_i, fec_i, dq_ready_i, pkt_det_i, pkt_det_en_i;
    logic [7:0] ilv_level_i;
    logic       task_wr_i, mode_wr_i, mode_bb_en_i, mode_tx_i, mode_irq_en_i, mode_dq_en_i;
    logic [3:0] task_code_i;
    logic [7:0] stat2_i;
    logic       rd_stat1_i, rd_stat2_i;
    logic [7:0] status1_o;
    logic       irq_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    modem_irq_status dut (.*);

    typedef struct packed {
        logic       brdy, ovf, fec, dq, pkt, pken, twr;
        logic [3:0] tc;
        logic       rd1, rd2;
        logic [7:0] s2;
        logic [7:0] exp;
        logic       expn;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    // brdy ovf fec dq pkt pken twr tc rd1 rd2 s2 exp expn req
    localparam vec_t VEC [NV] = '{
        '{0,0,0,0,0,0,0,4'h0,0,0,8'h00,8'h60,1,4'd1},  // R1 idle
        '{0,0,0,0,0,0,1,4'h3,0,0,8'h00,8'h20,1,4'd4},  // R4 data task clears
        '{0,0,0,0,0,0,1,4'h0,0,0,8'h00,8'h20,1,4'd4},  // R4 no-op keeps
        '{0,0,0,0,0,0,1,4'h2,0,0,8'h00,8'h20,1,4'd4},  // R4 stop keeps
        '{1,0,0,0,0,0,0,4'h0,0,0,8'h00,8'hE0,0,4'd2},  // R2 ready rise
        '{0,0,0,0,0,0,0,4'h0,1,0,8'h00,8'h60,1,4'd10}, // R10 read clears
        '{0,0,1,0,0,0,0,4'h0,0,0,8'h00,8'h68,1,4'd14}, // R14 fec mirrors
        '{0,1,0,0,0,0,0,4'h0,0,0,8'h00,8'hF0,0,4'd7},  // R7 overflow rise
        '{0,1,0,0,0,0,0,4'h0,1,0,8'h00,8'h70,1,4'd10}, // R10
        '{0,0,0,0,1,0,0,4'h0,0,0,8'h00,8'h61,1,4'd8},  // R8 disabled
        '{0,0,0,0,0,0,0,4'h0,0,0,8'h00,8'h60,1,4'd14}, // R14
        '{0,0,0,0,1,1,0,4'h0,0,0,8'h00,8'hE1,0,4'd8},  // R8 enabled
        '{0,0,0,0,1,1,0,4'h0,1,0,8'h00,8'h61,1,4'd10}, // R10
        '{0,0,0,1,0,0,0,4'h0,0,0,8'h00,8'hE4,0,4'd6},  // R6 enabled
        '{0,0,0,1,0,0,0,4'h0,1,0,8'h00,8'h64,1,4'd10}, // R10
        '{0,0,0,0,0,0,0,4'h0,0,0,8'h70,8'h60,1,4'd9},  // R9 masked bits
        '{0,0,0,0,0,0,0,4'h0,0,0,8'h71,8'hE0,0,4'd9},  // R9 bit0 rise
        '{0,0,0,0,0,0,0,4'h0,1,0,8'h71,8'hE0,0,4'd11}, // R11 primary read
        '{0,0,0,0,0,0,0,4'h0,0,1,8'h71,8'h60,1,4'd11}, // R11 secondary read
        '{0,0,0,0,0,0,0,4'h0,0,1,8'h79,8'hE0,0,4'd13}, // R13 rise vs read
        '{0,0,0,0,0,0,0,4'h0,0,1,8'h79,8'h60,1,4'd11}, // R11
        '{0,1,0,0,0,0,0,4'h0,0,0,8'hF9,8'hF0,0,4'd9},  // R9 bit7 + ovf
        '{0,1,0,0,0,0,0,4'h0,1,0,8'hF9,8'hF0,0,4'd11}, // R11 both origins
        '{0,1,0,0,0,0,0,4'h0,0,1,8'hF9,8'h70,1,4'd11}, // R11
        '{0,0,0,0,0,0,0,4'h0,0,0,8'h00,8'h60,1,4'd9},  // R9 falls ignored
        '{0,0,0,0,0,0,1,4'h5,0,0,8'h00,8'h20,1,4'd4},  // R4
        '{0,0,0,0,0,0,1,4'h1,0,0,8'h00,8'h60,1,4'd3}   // R3 reset task
    };

    task automatic clear_inputs();
        buf_ready_i = 0; ovf_i = 0; fec_i = 0; dq_ready_i = 0; pkt_det_i = 0;
        pkt_det_en_i = 0; task_wr_i = 0; task_code_i = 0; mode_wr_i = 0;
        rd_stat1_i = 0; rd_stat2_i = 0;
    endtask

    task automatic check(input string req, input logic [7:0] exp, input logic expn);
        n_chk++;
        if (status1_o !== exp || irq_n_o !== expn) begin
            n_bad++;
            $display("FAIL %s: status=%h irq_n=%b expected status=%h irq_n=%b",
                     req, status1_o, irq_n_o, exp, expn);
        end
    endtask

    // Apply held inputs across one edge, then sample
    task automatic step_check(input string req, input logic [7:0] exp, input logic expn);
        @(posedge clk); #1;
        check(req, exp, expn);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic mode_write(input logic bb, input logic tx, input logic ie, input logic de);
        mode_wr_i = 1; mode_bb_en_i = bb; mode_tx_i = tx;
        mode_irq_en_i = ie; mode_dq_en_i = de;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: status=%h irq_n=%b expected completion", status1_o, irq_n_o);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        mode_bb_en_i = 0; mode_tx_i = 0; mode_irq_en_i = 0; mode_dq_en_i = 0;
        stat2_i = 0; ilv_level_i = 0; rst_n = 0;
        repeat (2) @(posedge clk);
        #1 check("R1 reset", 8'h60, 1'b1);
        @(negedge clk); rst_n = 1;
        // enables on, direction unchanged: not a forced update
        mode_write(0, 0, 1, 1);
        step_check("R3 enable-only write", 8'h60, 1'b1);

        for (int i = 0; i < NV; i++) begin
            buf_ready_i = VEC[i].brdy; ovf_i = VEC[i].ovf; fec_i = VEC[i].fec;
            dq_ready_i = VEC[i].dq; pkt_det_i = VEC[i].pkt; pkt_det_en_i = VEC[i].pken;
            task_wr_i = VEC[i].twr; task_code_i = VEC[i].tc;
            rd_stat1_i = VEC[i].rd1; rd_stat2_i = VEC[i].rd2; stat2_i = VEC[i].s2;
            @(posedge clk); #1;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp, VEC[i].expn);
            @(negedge clk);
            clear_inputs();
        end

        // Directed: switch to transmit, forced update with no request (R3)
        ilv_level_i = 8'd10; mode_write(0, 1, 1, 1);
        step_check("R3 tx switch", 8'h62, 1'b1);
        step_check("R5 level high", 8'h42, 1'b1);
        ilv_level_i = 8'd1;
        step_check("R5 level below two", 8'hE2, 1'b0);
        ilv_level_i = 8'd2; rd_stat1_i = 1;
        step_check("R10 clear in tx", 8'h42, 1'b1);
        // Pin gating (R12)
        ilv_level_i = 8'd5; mode_write(0, 1, 0, 1);
        step_check("R12 disable pin", 8'h42, 1'b1);
        ovf_i = 1;
        step_check("R12 irq masked on pin", 8'hD2, 1'b1);
        ovf_i = 1; mode_write(0, 1, 1, 1);
        step_check("R12 pin re-enabled", 8'hD2, 1'b0);
        ovf_i = 1; rd_stat1_i = 1;
        step_check("R10", 8'h52, 1'b1);
        // Data-quality enable off (R6)
        mode_write(0, 1, 1, 0);
        step_check("R6 dq disable", 8'h42, 1'b1);
        dq_ready_i = 1;
        step_check("R6 dq masked", 8'h46, 1'b1);
        // Baseband change is forced (R3)
        mode_write(1, 1, 1, 0);
        step_check("R3 baseband change", 8'h62, 1'b1);
        // Synchronous reset mid-run (R1)
        ovf_i = 1; rst_n = 0;
        step_check("R1 mid-run reset", 8'h60, 1'b1);
        rst_n = 1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule